// File: doc/BRIEF.md
# Data-Side Address Translation Unit

This block turns the virtual address of a load or store into a physical address. It raises a fault class and a six-bit memory-status word when the access cannot go ahead. A request is accepted in any cycle where `req_valid` is high. The result appears on the response ports one cycle later, qualified by `resp_valid`. The checks run in a fixed priority order: alignment first, then the physical bypass, then the canonical-form test, then the kernel superpage window, and last the lookup in a small fully associative table with its permission and fault-on bits. Machine check is tested last, on an otherwise successful result. Alongside the result, the block pulses separate read and write strobes for hit, miss, violation and table access, so that event counters outside the block can tally them.

While the program counter carries the privileged-code marker (its least significant bit), the mode used for the permission check is overridden. It becomes the alternate mode when the request asks for it, and kernel otherwise. The table is loaded through a single write port. Refill policy, replacement choice and cacheability lie outside the block.

The control is a two-state machine. In `S_IDLE` no response is pending. In `S_RESP` the output registers hold a valid result. The transition `T_ACCEPT` (idle to respond) and the transition `T_STREAM` (respond to respond) both occur when `req_valid` is high. The transition `T_DRAIN` (respond to idle) occurs when `req_valid` is low.

Top module: `dtx_unit`

## Requirements
- R1: When any address bit below the access size (1, 2, 4 or 8 bytes for `req_size` 0 to 3) is set, the fault is ALIGN (code 1). The status holds only the write bit (bit 0, set for stores). No strobe fires. This check overrides every other.
- R2: The permission mode is `alt_mode` when the PC marker bit is 1 and `req_alt` is 1. It is kernel (0) when the PC marker bit is 1 and `req_alt` is 0. It is `cur_mode` when the PC marker bit is 0. Permission masks are indexed by mode (bit 0 kernel, bit 1 executive, bit 2 supervisor, bit 3 user).
- R3: With `req_phys` set, the physical address is `req_va[43:0]` and the table is not consulted. No strobe fires. If any of `req_va[63:44]` is set, the fault is MCHK (code 6) with a zero status.
- R4: If `req_va[63:47]` is neither all zeros nor all ones, the fault is PAGE (code 3). The status sets bad-VA (bit 5), ACV (bit 1) and the write bit for stores, and a violation strobe fires.
- R5: If `req_va[47:41]` equals 0x7e and `cur_mode` is not kernel, the fault is ACV (code 2) with status ACV plus write, and a violation strobe fires. Otherwise the physical address is `req_va[40:0]` with bits 43:41 copied from `req_va[40]`, and a hit strobe fires.
- R6: A table miss gives MISS2 (code 5) when `req_pte` is set and MISS1 (code 4) otherwise. The status sets miss (bit 4) plus write for stores. The access strobe and the miss strobe fire.
- R7: On a store hit, a clear write-enable bit for the mode gives PAGE with status write and ACV, plus FOW (bit 3) if the entry's fault-on-write bit is set. If the write-enable bit is set but fault-on-write is set, the result is PAGE with status write and FOW. In both cases the violation strobe fires.
- R8: On a load hit, a clear read-enable bit for the mode gives ACV with status ACV, plus FOR (bit 2) if the entry's fault-on-read bit is set. If the read-enable bit is set but fault-on-read is set, the result is PAGE with status FOR only. In both cases the violation strobe fires.
- R9: On a permitted table hit, the physical address is the PPN shifted left by 13 with the full 13-bit page offset added, and no low bits are cleared. If that sum has any bit at or above bit 44 set, the fault is MCHK. Otherwise it is NONE (code 0). The hit strobe fires in both cases.
- R10: Strobes are split by direction: the `rd_*` strobes fire for loads and the `wr_*` strobes fire for stores. At most one of hit, miss and violation fires per response, and all strobes are low when `resp_valid` is low.
- R11: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Out of reset it is low and all strobes are low.
- R12: A table entry written through the load port matches only when its VPN equals `req_va[47:13]` and its ASN equals `cur_asn`. An ASN mismatch is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_pc_tag | input | 1 | PC least significant bit (privileged-code marker) |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use the alternate mode under privileged code |
| req_pte | input | 1 | Access is a page-table-entry fetch |
| cur_mode | input | 2 | Current mode (0 kernel, 1 executive, 2 supervisor, 3 user) |
| alt_mode | input | 2 | Alternate mode |
| cur_asn | input | 8 | Current address-space number |
| ent_we | input | 1 | Write a table entry |
| ent_idx | input | 3 | Entry slot to write |
| ent_vpn | input | 35 | Entry virtual page number |
| ent_asn | input | 8 | Entry address-space number |
| ent_ppn | input | 32 | Entry physical page number |
| ent_rd_mask | input | 4 | Read enable for each mode |
| ent_wr_mask | input | 4 | Write enable for each mode |
| ent_for | input | 1 | Fault on read |
| ent_fow | input | 1 | Fault on write |
| resp_valid | output | 1 | Response valid |
| resp_pa | output | 44 | Physical address |
| resp_fault | output | 3 | Fault class code |
| resp_status | output | 6 | Memory-status word |
| rd_hit | output | 1 | Load hit strobe |
| rd_miss | output | 1 | Load miss strobe |
| rd_viol | output | 1 | Load violation strobe |
| rd_acc | output | 1 | Load table-access strobe |
| wr_hit | output | 1 | Store hit strobe |
| wr_miss | output | 1 | Store miss strobe |
| wr_viol | output | 1 | Store violation strobe |
| wr_acc | output | 1 | Store table-access strobe |

## Verification
The bench targets the priority edges. A misaligned non-canonical address must report ALIGN; a design that tested canonical form first would report PAGE with bad-VA. Permission faults are exercised with fault-on bits both set and clear. A design that dropped the FOR bit on a read-enable violation, or reported a pure fault-on-read as ACV, would show the wrong status or class. The bench covers the privileged-code mode override with and without the alternate flag, and physical accesses with upper bits set. It also covers superpage addresses on both sides of bit 40, a user-mode superpage access, and an ASN mismatch that must miss even though the VPN matches. A swapped direction strobe, or a superpage copy of bit 40 into the wrong upper bits, would show up as a mismatched strobe vector or address.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_ACV   = 3'd2,
        FLT_PAGE  = 3'd3,
        FLT_MISS1 = 3'd4,
        FLT_MISS2 = 3'd5,
        FLT_MCHK  = 3'd6
    } fault_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_e;

    // status word bit positions
    localparam int ST_WR   = 0;
    localparam int ST_ACV  = 1;
    localparam int ST_FOR  = 2;
    localparam int ST_FOW  = 3;
    localparam int ST_MISS = 4;
    localparam int ST_BADV = 5;
    localparam int ST_W    = 6;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dtx_table.sv
module dtx_table #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 35,
    parameter int ASN_W   = 8,
    parameter int PPN_W   = 32,
    parameter int MODES   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [VPN_W-1:0] w_vpn,
    input  logic [ASN_W-1:0] w_asn,
    input  logic [PPN_W-1:0] w_ppn,
    input  logic [MODES-1:0] w_rd_mask,
    input  logic [MODES-1:0] w_wr_mask,
    input  logic             w_for,
    input  logic             w_fow,
    input  logic [VPN_W-1:0] q_vpn,
    input  logic [ASN_W-1:0] q_asn,
    output logic             q_hit,
    output logic [PPN_W-1:0] q_ppn,
    output logic [MODES-1:0] q_rd_mask,
    output logic [MODES-1:0] q_wr_mask,
    output logic             q_for,
    output logic             q_fow
);
    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   vpn_r  [ENTRIES];
    logic [ASN_W-1:0]   asn_r  [ENTRIES];
    logic [PPN_W-1:0]   ppn_r  [ENTRIES];
    logic [MODES-1:0]   rdm_r  [ENTRIES];
    logic [MODES-1:0]   wrm_r  [ENTRIES];
    logic [ENTRIES-1:0] for_r, fow_r, match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[g]   <= 1'b0;
                vpn_r[g] <= '0;
                asn_r[g] <= '0;
                ppn_r[g] <= '0;
                rdm_r[g] <= '0;
                wrm_r[g] <= '0;
                for_r[g] <= 1'b0;
                fow_r[g] <= 1'b0;
            end else if (we && w_idx == IDX_W'(g)) begin
                vld[g]   <= 1'b1;
                vpn_r[g] <= w_vpn;
                asn_r[g] <= w_asn;
                ppn_r[g] <= w_ppn;
                rdm_r[g] <= w_rd_mask;
                wrm_r[g] <= w_wr_mask;
                for_r[g] <= w_for;
                fow_r[g] <= w_fow;
            end
        end
        assign match[g] = vld[g] && vpn_r[g] == q_vpn && asn_r[g] == q_asn;
    end

    // lowest matching slot wins
    always_comb begin
        q_hit = 1'b0;
        q_ppn = '0;
        q_rd_mask = '0;
        q_wr_mask = '0;
        q_for = 1'b0;
        q_fow = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                q_hit = 1'b1;
                q_ppn = ppn_r[i];
                q_rd_mask = rdm_r[i];
                q_wr_mask = wrm_r[i];
                q_for = for_r[i];
                q_fow = fow_r[i];
            end
        end
    end
endmodule

// File: rtl/dtx_check.sv
module dtx_check
    import dtx_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int IMPL_VA  = 48,
    parameter int PA_W     = 44,
    parameter int PG_SHIFT = 13,
    parameter int PPN_W    = 32,
    parameter int MODES    = 4,
    parameter int SP_HI    = 47,
    parameter int SP_LO    = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
    localparam int FULL_W  = PPN_W + PG_SHIFT
) (
    input  logic [VA_W-1:0]  va,
    input  logic [1:0]       size,
    input  logic             wr,
    input  logic             pc_tag,
    input  logic             phys,
    input  logic             alt,
    input  logic             pte,
    input  logic [1:0]       cur_mode,
    input  logic [1:0]       alt_mode,
    input  logic             hit,
    input  logic [PPN_W-1:0] ppn,
    input  logic [MODES-1:0] rd_mask,
    input  logic [MODES-1:0] wr_mask,
    input  logic             f_or,
    input  logic             f_ow,
    output fault_e           fault,
    output logic [ST_W-1:0]  status,
    output logic [PA_W-1:0]  pa,
    output logic             s_hit,
    output logic             s_miss,
    output logic             s_viol,
    output logic             s_acc
);
    logic [1:0]        eff_mode;
    logic [7:0]        amask;
    logic [FULL_W-1:0] full_pa;
    logic              canon;

    assign eff_mode = pc_tag ? (alt ? alt_mode : MODE_KERNEL) : cur_mode;
    assign amask    = (8'd1 << size) - 8'd1;
    assign full_pa  = {ppn, va[PG_SHIFT-1:0]};
    assign canon    = (&va[VA_W-1:IMPL_VA-1]) || !(|va[VA_W-1:IMPL_VA-1]);

    always_comb begin
        fault  = FLT_NONE;
        status = '0;
        pa     = '0;
        s_hit  = 1'b0;
        s_miss = 1'b0;
        s_viol = 1'b0;
        s_acc  = 1'b0;
        if ((va[7:0] & amask) != 8'd0) begin
            fault = FLT_ALIGN;
            status[ST_WR] = wr;
        end else if (phys) begin
            pa = va[PA_W-1:0];
            if (|va[VA_W-1:PA_W]) fault = FLT_MCHK;
        end else if (!canon) begin
            fault = FLT_PAGE;
            status[ST_WR] = wr;
            status[ST_ACV] = 1'b1;
            status[ST_BADV] = 1'b1;
            s_viol = 1'b1;
        end else if (va[SP_HI:SP_LO] == SP_TAG) begin
            if (cur_mode != MODE_KERNEL) begin
                fault = FLT_ACV;
                status[ST_WR] = wr;
                status[ST_ACV] = 1'b1;
                s_viol = 1'b1;
            end else begin
                pa = {{(PA_W-SP_LO){va[SP_LO-1]}}, va[SP_LO-1:0]};
                s_hit = 1'b1;
            end
        end else begin
            s_acc = 1'b1;
            if (!hit) begin
                fault = pte ? FLT_MISS2 : FLT_MISS1;
                status[ST_WR] = wr;
                status[ST_MISS] = 1'b1;
                s_miss = 1'b1;
            end else begin
                pa = full_pa[PA_W-1:0];
                if (wr && !wr_mask[eff_mode]) begin
                    fault = FLT_PAGE;
                    status[ST_WR] = 1'b1;
                    status[ST_ACV] = 1'b1;
                    status[ST_FOW] = f_ow;
                    s_viol = 1'b1;
                end else if (wr && f_ow) begin
                    fault = FLT_PAGE;
                    status[ST_WR] = 1'b1;
                    status[ST_FOW] = 1'b1;
                    s_viol = 1'b1;
                end else if (!wr && !rd_mask[eff_mode]) begin
                    fault = FLT_ACV;
                    status[ST_ACV] = 1'b1;
                    status[ST_FOR] = f_or;
                    s_viol = 1'b1;
                end else if (!wr && f_or) begin
                    fault = FLT_PAGE;
                    status[ST_FOR] = 1'b1;
                    s_viol = 1'b1;
                end else begin
                    s_hit = 1'b1;
                    if (|full_pa[FULL_W-1:PA_W]) fault = FLT_MCHK;
                end
            end
        end
    end
endmodule

// File: rtl/dtx_unit.sv
module dtx_unit
    import dtx_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int IMPL_VA  = 48,
    parameter int PA_W     = 44,
    parameter int PG_SHIFT = 13,
    parameter int PPN_W    = 32,
    parameter int ASN_W    = 8,
    parameter int ENTRIES  = 8,
    parameter int MODES    = 4,
    localparam int VPN_W   = IMPL_VA - PG_SHIFT,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_size,
    input  logic             req_write,
    input  logic             req_pc_tag,
    input  logic             req_phys,
    input  logic             req_alt,
    input  logic             req_pte,
    input  logic [1:0]       cur_mode,
    input  logic [1:0]       alt_mode,
    input  logic [ASN_W-1:0] cur_asn,
    input  logic             ent_we,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [ASN_W-1:0] ent_asn,
    input  logic [PPN_W-1:0] ent_ppn,
    input  logic [MODES-1:0] ent_rd_mask,
    input  logic [MODES-1:0] ent_wr_mask,
    input  logic             ent_for,
    input  logic             ent_fow,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_pa,
    output logic [2:0]       resp_fault,
    output logic [ST_W-1:0]  resp_status,
    output logic             rd_hit,
    output logic             rd_miss,
    output logic             rd_viol,
    output logic             rd_acc,
    output logic             wr_hit,
    output logic             wr_miss,
    output logic             wr_viol,
    output logic             wr_acc
);
    state_e state, state_nx;

    logic             t_hit, t_for, t_fow;
    logic [PPN_W-1:0] t_ppn;
    logic [MODES-1:0] t_rdm, t_wrm;
    fault_e           c_fault;
    logic [ST_W-1:0]  c_status;
    logic [PA_W-1:0]  c_pa;
    logic             c_hit, c_miss, c_viol, c_acc;

    dtx_table #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .MODES(MODES)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(ent_we), .w_idx(ent_idx), .w_vpn(ent_vpn), .w_asn(ent_asn), .w_ppn(ent_ppn),
        .w_rd_mask(ent_rd_mask), .w_wr_mask(ent_wr_mask), .w_for(ent_for), .w_fow(ent_fow),
        .q_vpn(req_va[IMPL_VA-1:PG_SHIFT]), .q_asn(cur_asn),
        .q_hit(t_hit), .q_ppn(t_ppn), .q_rd_mask(t_rdm), .q_wr_mask(t_wrm),
        .q_for(t_for), .q_fow(t_fow)
    );

    dtx_check #(
        .VA_W(VA_W), .IMPL_VA(IMPL_VA), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
        .PPN_W(PPN_W), .MODES(MODES)
    ) u_check (
        .va(req_va), .size(req_size), .wr(req_write), .pc_tag(req_pc_tag),
        .phys(req_phys), .alt(req_alt), .pte(req_pte),
        .cur_mode(cur_mode), .alt_mode(alt_mode),
        .hit(t_hit), .ppn(t_ppn), .rd_mask(t_rdm), .wr_mask(t_wrm),
        .f_or(t_for), .f_ow(t_fow),
        .fault(c_fault), .status(c_status), .pa(c_pa),
        .s_hit(c_hit), .s_miss(c_miss), .s_viol(c_viol), .s_acc(c_acc)
    );

    // next-state logic: T_ACCEPT / T_STREAM on a request, T_DRAIN otherwise
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nx = S_RESP;
            S_RESP: if (!req_valid) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    assign resp_valid = (state == S_RESP);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_pa     <= '0;
            resp_fault  <= FLT_NONE;
            resp_status <= '0;
            {rd_hit, rd_miss, rd_viol, rd_acc} <= '0;
            {wr_hit, wr_miss, wr_viol, wr_acc} <= '0;
        end else begin
            {rd_hit, rd_miss, rd_viol, rd_acc} <=
                (req_valid && !req_write) ? {c_hit, c_miss, c_viol, c_acc} : 4'b0;
            {wr_hit, wr_miss, wr_viol, wr_acc} <=
                (req_valid && req_write) ? {c_hit, c_miss, c_viol, c_acc} : 4'b0;
            if (req_valid) begin
                resp_pa     <= c_pa;
                resp_fault  <= c_fault;
                resp_status <= c_status;
            end
        end
    end
endmodule

// File: rtl/dtx_unit_chk.sv
module dtx_unit_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_write,
    input logic            req_phys,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_pa,
    input logic [2:0]      resp_fault,
    input logic [5:0]      resp_status,
    input logic            rd_hit,
    input logic            rd_miss,
    input logic            rd_viol,
    input logic            rd_acc,
    input logic            wr_hit,
    input logic            wr_miss,
    input logic            wr_viol,
    input logic            wr_acc
);
    a_r1_align_status: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 3'd1) |->
            (resp_status[5:1] == 5'd0 && resp_status[0] == $past(req_write)));

    a_r3_phys_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(req_phys) && resp_fault == 3'd0) |->
            (resp_pa == $past(req_va[PA_W-1:0])));

    a_r6_miss_status: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_fault == 3'd4 || resp_fault == 3'd5)) |->
            (resp_status[4] && (rd_miss || wr_miss) && (rd_acc || wr_acc)));

    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_hit, rd_miss, rd_viol, wr_hit, wr_miss, wr_viol}));

    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |->
            !(rd_hit | rd_miss | rd_viol | rd_acc | wr_hit | wr_miss | wr_viol | wr_acc));

    a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
endmodule

bind dtx_unit dtx_unit_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_phys(req_phys), .resp_valid(resp_valid),
    .resp_pa(resp_pa), .resp_fault(resp_fault), .resp_status(resp_status),
    .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_viol(rd_viol), .rd_acc(rd_acc),
    .wr_hit(wr_hit), .wr_miss(wr_miss), .wr_viol(wr_viol), .wr_acc(wr_acc)
);

// File: tb/dtx_unit_tb.sv
module dtx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0, req_pc_tag = 1'b0, req_phys = 1'b0;
    logic        req_alt = 1'b0, req_pte = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic [7:0]  cur_asn = '0;
    logic        ent_we = 1'b0;
    logic [2:0]  ent_idx = '0;
    logic [34:0] ent_vpn = '0;
    logic [7:0]  ent_asn = '0;
    logic [31:0] ent_ppn = '0;
    logic [3:0]  ent_rd_mask = '0, ent_wr_mask = '0;
    logic        ent_for = 1'b0, ent_fow = 1'b0;
    logic        resp_valid;
    logic [43:0] resp_pa;
    logic [2:0]  resp_fault;
    logic [5:0]  resp_status;
    logic        rd_hit, rd_miss, rd_viol, rd_acc, wr_hit, wr_miss, wr_viol, wr_acc;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // bench copy of the table
    logic        m_vld [8];
    logic [34:0] m_vpn [8];
    logic [7:0]  m_asn [8];
    logic [31:0] m_ppn [8];
    logic [3:0]  m_rdm [8], m_wrm [8];
    logic        m_for [8], m_fow [8];

    always #5 clk = ~clk;

    dtx_unit u_dut (.*);

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // reference computed from the requirements
    function automatic void model(
        input logic [63:0] va, input logic [1:0] sz, input logic w, pct, ph, al, pt,
        input logic [1:0] cm, am, input logic [7:0] asn,
        output logic [43:0] pa, output logic [2:0] f, output logic [5:0] st,
        output logic [3:0] ev);   // ev = {hit, miss, viol, acc}
        logic [1:0]  em;
        logic [44:0] full;
        int          hi;
        pa = '0; f = 3'd0; st = '0; ev = '0; hi = -1;
        em = pct ? (al ? am : 2'd0) : cm;                               // R2
        if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin                   // R1
            f = 3'd1; st[0] = w;
        end else if (ph) begin                                           // R3
            pa = va[43:0];
            if (va[63:44] != 0) f = 3'd6;
        end else if (!(va[63:47] == '0 || va[63:47] == '1)) begin        // R4
            f = 3'd3; st = {1'b1, 3'b0, 1'b1, w}; ev = 4'b0010;
        end else if (va[47:41] == 7'h7e) begin                           // R5
            if (cm != 2'd0) begin f = 3'd2; st = {4'b0, 1'b1, w}; ev = 4'b0010; end
            else begin pa = {{3{va[40]}}, va[40:0]}; ev = 4'b1000; end
        end else begin
            for (int i = 7; i >= 0; i--)                                 // R12
                if (m_vld[i] && m_vpn[i] == va[47:13] && m_asn[i] == asn) hi = i;
            if (hi < 0) begin                                            // R6
                f = pt ? 3'd5 : 3'd4; st = {1'b0, 1'b1, 3'b0, w}; ev = 4'b0101;
            end else begin
                full = {m_ppn[hi], va[12:0]};
                pa = full[43:0];
                if (w && !m_wrm[hi][em]) begin                           // R7
                    f = 3'd3; st = {2'b0, m_fow[hi], 1'b0, 1'b1, 1'b1}; ev = 4'b0011;
                end else if (w && m_fow[hi]) begin
                    f = 3'd3; st = 6'b001001; ev = 4'b0011;
                end else if (!w && !m_rdm[hi][em]) begin                 // R8
                    f = 3'd2; st = {3'b0, m_for[hi], 1'b1, 1'b0}; ev = 4'b0011;
                end else if (!w && m_for[hi]) begin
                    f = 3'd3; st = 6'b000100; ev = 4'b0011;
                end else begin                                           // R9
                    ev = 4'b1001;
                    if (full[44]) f = 3'd6;
                end
            end
        end
    endfunction

    task automatic load_entry(input int i, input logic [34:0] vpn, input logic [7:0] asn,
                              input logic [31:0] ppn, input logic [3:0] rm, wm,
                              input logic fr, fw);
        @(negedge clk);
        ent_we = 1'b1; ent_idx = 3'(i); ent_vpn = vpn; ent_asn = asn; ent_ppn = ppn;
        ent_rd_mask = rm; ent_wr_mask = wm; ent_for = fr; ent_fow = fw;
        m_vld[i] = 1'b1; m_vpn[i] = vpn; m_asn[i] = asn; m_ppn[i] = ppn;
        m_rdm[i] = rm; m_wrm[i] = wm; m_for[i] = fr; m_fow[i] = fw;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic run_req(input string tag, input logic [63:0] va, input logic [1:0] sz,
                           input logic w, pct, ph, al, pt, input logic [1:0] cm, am,
                           input logic [7:0] asn);
        logic [43:0] e_pa; logic [2:0] e_f; logic [5:0] e_st; logic [3:0] ev;
        logic [7:0] e_sb, a_sb;
        model(va, sz, w, pct, ph, al, pt, cm, am, asn, e_pa, e_f, e_st, ev);
        e_sb = w ? {ev, 4'b0} : {4'b0, ev};
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_size = sz; req_write = w; req_pc_tag = pct;
        req_phys = ph; req_alt = al; req_pte = pt; cur_mode = cm; alt_mode = am;
        cur_asn = asn;
        @(negedge clk);
        req_valid = 1'b0;
        a_sb = {wr_hit, wr_miss, wr_viol, wr_acc, rd_hit, rd_miss, rd_viol, rd_acc};
        n_tests++;
        // R11: response lands one cycle after the request
        if (!resp_valid || resp_fault != e_f || resp_status != e_st || a_sb != e_sb ||
            ((e_f == 3'd0 || e_f == 3'd6) && resp_pa != e_pa)) begin
            n_fail++;
            $display("FAIL %s va=%h: actual v=%b f=%0d st=%b sb=%b pa=%h expected f=%0d st=%b sb=%b pa=%h",
                     tag, va, resp_valid, resp_fault, resp_status, a_sb, resp_pa,
                     e_f, e_st, e_sb, e_pa);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        n_tests++;   // R11 reset state
        if (resp_valid || {rd_hit, rd_miss, rd_viol, rd_acc, wr_hit, wr_miss, wr_viol, wr_acc} != 0) begin
            n_fail++;
            $display("FAIL R11 reset: actual v=%b expected v=0, strobes 0", resp_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;   // R11 idle after reset
        if (resp_valid) begin
            n_fail++;
            $display("FAIL R11 idle: actual v=1 expected v=0");
        end

        load_entry(0, 35'h0_0000_1234, 8'h05, 32'h0000_0abc, 4'b1111, 4'b1111, 1'b0, 1'b0);
        load_entry(1, 35'h0_0000_2000, 8'h05, 32'h0000_0111, 4'b0001, 4'b0001, 1'b1, 1'b1);
        load_entry(2, 35'h0_0000_3000, 8'h05, 32'h0000_0222, 4'b1111, 4'b1111, 1'b1, 1'b1);
        load_entry(3, 35'h0_0000_4000, 8'h05, 32'h8000_0001, 4'b1111, 4'b1111, 1'b0, 1'b0);

        // directed corners
        run_req("R1", 64'h00f0_0000_0000_0003, 2'd2, 1'b1, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R1", 64'h0000_0000_0246_8001, 2'd1, 1'b0, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R3", 64'h0000_0abc_dead_bee8, 2'd3, 1'b0, 0, 1, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R3", 64'h0001_0abc_dead_bee8, 2'd3, 1'b1, 0, 1, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R4", 64'h0001_0000_0000_0000, 2'd0, 1'b1, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R5", 64'hffff_fd00_1234_5678, 2'd3, 1'b0, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R5", 64'hffff_fc00_1234_5678, 2'd3, 1'b0, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R5", 64'hffff_fc00_1234_5678, 2'd3, 1'b1, 1, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R6", 64'h0000_0000_0999_0000, 2'd0, 1'b0, 0, 0, 0, 1, 2'd0, 2'd0, 8'h05);
        run_req("R6", 64'h0000_0000_0999_0000, 2'd0, 1'b1, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R12", {16'h0, 35'h0_0000_1234, 13'h10}, 2'd0, 1'b0, 0, 0, 0, 0, 2'd0, 2'd0, 8'h06);
        run_req("R9", {16'h0, 35'h0_0000_1234, 13'h1ff7}, 2'd0, 1'b0, 0, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R9", {16'h0, 35'h0_0000_4000, 13'h8}, 2'd3, 1'b0, 0, 0, 0, 0, 2'd0, 2'd0, 8'h05);
        run_req("R7", {16'h0, 35'h0_0000_2000, 13'h8}, 2'd3, 1'b1, 0, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R7", {16'h0, 35'h0_0000_3000, 13'h8}, 2'd3, 1'b1, 0, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R8", {16'h0, 35'h0_0000_2000, 13'h8}, 2'd3, 1'b0, 0, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R8", {16'h0, 35'h0_0000_3000, 13'h8}, 2'd3, 1'b0, 0, 0, 0, 0, 2'd3, 2'd0, 8'h05);
        run_req("R2", {16'h0, 35'h0_0000_2000, 13'h8}, 2'd3, 1'b0, 1, 0, 0, 0, 2'd3, 2'd2, 8'h05);
        run_req("R2", {16'h0, 35'h0_0000_2000, 13'h8}, 2'd3, 1'b0, 1, 0, 1, 0, 2'd0, 2'd2, 8'h05);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [63:0] va; logic [34:0] vpn; int k; int cat;
            cat = $urandom % 6;
            k = $urandom % 4;
            vpn = (cat == 4) ? 35'($urandom) : m_vpn[k];
            case (cat)
                0: va = {(($urandom % 3) == 0) ? 20'($urandom) : 20'h0, 12'($urandom), 32'($urandom)};
                1: va = {17'h0_0f0f, 15'($urandom), 32'($urandom)};
                2: va = {16'hffff, 7'h7e, 9'($urandom), 32'($urandom)};
                default: va = {{16{vpn[34]}}, vpn, 13'($urandom)};
            endcase
            if (($urandom % 4) != 0) va[2:0] = 3'b000;
            run_req(cat == 0 ? "R3" : cat == 1 ? "R4" : cat == 2 ? "R5" :
                    cat == 4 ? "R6" : "R10",
                    va, 2'($urandom), 1'($urandom), 1'($urandom), cat == 0,
                    1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                    (($urandom % 8) == 0) ? 8'h07 : 8'h05);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule